// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Reset Pulse

This block watches for a stalled system. The peripheral clock first passes through an 8-bit prescaler. It then passes through a frequency divider with four settings. The result clocks a 16-bit counter that counts down. Software must write the count register from time to time to push the counter back up. If it fails to, the counter runs out, and the block can drive a system reset for a fixed number of clock cycles, raise an interrupt, or do both. After each expiry the counter refills from a reload register and keeps running. With reset turned off, the same block serves as a plain interval timer that raises periodic interrupts.

Software uses four 16-bit registers over a simple write strobe with a 4-bit byte offset. Reads are combinational on the offset. The registers are control, reload value, live count and interrupt acknowledge.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0x0021 (run and reset-on-expiry set), the reload and count registers both read 0x8000, and `wdt_rst` and `wdt_irq` are low.
- R2: The registers sit at these offsets: 0x0 control, 0x4 reload, 0x8 count and 0xC interrupt acknowledge. Control reads back all 16 bits as written. The acknowledge register reads zero. A write to any other offset changes no register, and a read from any other offset returns zero.
- R3: Control bits [15:8] hold the prescaler value P, and bits [4:3] select the divider: 00 gives /16, 01 gives /32, 10 gives /64 and 11 gives /128. The counter ticks once every (P+1)×divide clock cycles.
- R4: Each tick lowers the count by one. A tick that finds the count at 1 or 0 is an expiry. On expiry the count loads the reload value and the timer keeps running, so a written count N of at least 1 expires N ticks after it is loaded, and a written 0 expires on the first tick.
- R5: A write to the count register loads the value at the next clock edge. The same write restarts the prescaler and divider phase, so expiry falls exactly N×(P+1)×divide cycles after that edge. Any expiry the earlier count was heading for is cancelled.
- R6: While control bit 5 (run) is clear, the counter holds its value and no expiry occurs.
- R7: While control bit 0 (reset enable) is set, an expiry drives `wdt_rst` high. The pulse begins in the cycle after the expiry edge and lasts exactly 128 clock cycles.
- R8: While control bit 2 (interrupt enable) is set, an expiry sets `wdt_irq`. The flag stays high, even across later expiries, until any write to offset 0xC clears it.
- R9: With reset enable clear, an expiry produces no reset pulse. With interrupt enable clear, an expiry leaves `wdt_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| wdt_rst | output | 1 | System reset pulse |
| wdt_irq | output | 1 | Expiry interrupt flag |

## Verification
The assertions assume that every write lasts exactly one cycle, with `addr` and `wdata` stable and fully defined while `wr_en` is high. The pulse-length check also assumes that no second expiry falls inside a running reset pulse. The bench drives all inputs on the falling edge and drops the strobe after one cycle. Before it tests the reset pulse, it loads the reload register with 0xFFFF, so the next expiry lands far past the end of the 128-cycle pulse. It also rewrites the control register before the default timeout can arrive.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned PRE_W  = 8;
    localparam int unsigned ADDR_W = 4;

    // control bit positions
    localparam int unsigned CTL_RST_BIT = 0;
    localparam int unsigned CTL_IRQ_BIT = 2;
    localparam int unsigned CTL_DIV_LO  = 3;
    localparam int unsigned CTL_RUN_BIT = 5;
    localparam int unsigned CTL_PRE_LO  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RELD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 4'hC;

    localparam logic [REG_W-1:0] CTRL_INIT = REG_W'(16'h0021);

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [1:0]       div_sel;
        logic             run;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c.presc   = raw[CTL_PRE_LO +: PRE_W];
        c.div_sel = raw[CTL_DIV_LO +: 2];
        c.run     = raw[CTL_RUN_BIT];
        c.irq_en  = raw[CTL_IRQ_BIT];
        c.rst_en  = raw[CTL_RST_BIT];
        return c;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [REG_W-1:0] CNT_INIT = REG_W'(16'h8000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  cnt,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  reload,
    output logic              cnt_we,
    output logic              irq,
    output logic [REG_W-1:0]  rdata
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl_raw;
        logic [REG_W-1:0] reload;
        logic             irq;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (addr)
                OFS_CTRL: s_d.ctrl_raw = wdata;
                OFS_RELD: s_d.reload   = wdata;
                OFS_ACK:  s_d.irq      = 1'b0;
                default:  ;
            endcase
        end
        if (expire && decode_ctrl(s_q.ctrl_raw).irq_en) begin
            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl_raw <= CTRL_INIT;
            s_q.reload   <= CNT_INIT;
            s_q.irq      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = s_q.ctrl_raw;
            OFS_RELD: rdata = s_q.reload;
            OFS_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end

    assign ctrl   = decode_ctrl(s_q.ctrl_raw);
    assign reload = s_q.reload;
    assign irq    = s_q.irq;
    assign cnt_we = wr_en && (addr == OFS_CNT);
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
#(
    parameter int unsigned DIV_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    input  logic [1:0]       div_sel,
    output logic             tick
);
    localparam int unsigned DIV_W = $clog2(DIV_BASE * 8);

    typedef struct packed {
        logic [PRE_W-1:0] pc;
        logic [DIV_W-1:0] dc;
    } phase_t;

    phase_t s_d, s_q;
    logic [DIV_W-1:0] div_last;
    logic             pre_hit;

    always_comb begin
        unique case (div_sel)
            2'd0:    div_last = DIV_W'(DIV_BASE - 1);
            2'd1:    div_last = DIV_W'(DIV_BASE * 2 - 1);
            2'd2:    div_last = DIV_W'(DIV_BASE * 4 - 1);
            default: div_last = DIV_W'(DIV_BASE * 8 - 1);
        endcase
    end

    assign pre_hit = run && (s_q.pc == presc);
    assign tick    = pre_hit && (s_q.dc >= div_last);

    always_comb begin
        s_d = s_q;
        if (restart || !run) begin
            s_d.pc = '0;
            s_d.dc = '0;
        end else if (pre_hit) begin
            s_d.pc = '0;
            s_d.dc = (s_q.dc >= div_last) ? '0 : s_q.dc + DIV_W'(1);
        end else begin
            s_d.pc = s_q.pc + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter logic [REG_W-1:0] CNT_INIT = REG_W'(16'h8000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic [REG_W-1:0] load_val,
    input  logic [REG_W-1:0] reload,
    output logic [REG_W-1:0] cnt,
    output logic             expire
);
    typedef struct packed {
        logic [REG_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;

    assign expire = tick && !load_we && (s_q.cnt <= REG_W'(1));

    always_comb begin
        s_d = s_q;
        if (load_we) begin
            s_d.cnt = load_val;
        end else if (tick) begin
            s_d.cnt = (s_q.cnt <= REG_W'(1)) ? reload : s_q.cnt - REG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= CNT_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int unsigned RST_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned RW = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic [RW-1:0] remain;
    } pulse_t;

    pulse_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.remain = RW'(RST_LEN);
        end else if (s_q.remain != '0) begin
            s_d.remain = s_q.remain - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = (s_q.remain != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned      RST_LEN  = 128,
    parameter int unsigned      DIV_BASE = 16,
    parameter logic [REG_W-1:0] CNT_INIT = REG_W'(16'h8000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              wdt_rst,
    output logic              wdt_irq
);
    ctrl_t            ctrl_w;
    logic [REG_W-1:0] reload_w;
    logic [REG_W-1:0] cnt_w;
    logic             kick_w;
    logic             tick_w;
    logic             expire_w;
    logic             run_w;
    logic             rst_en_w;
    logic             irq_en_w;

    assign run_w    = ctrl_w.run;
    assign rst_en_w = ctrl_w.rst_en;
    assign irq_en_w = ctrl_w.irq_en;

    wdog_regs #(.CNT_INIT(CNT_INIT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cnt    (cnt_w),
        .expire (expire_w),
        .ctrl   (ctrl_w),
        .reload (reload_w),
        .cnt_we (kick_w),
        .irq    (wdt_irq),
        .rdata  (rdata)
    );

    wdog_tick #(.DIV_BASE(DIV_BASE)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (kick_w),
        .presc   (ctrl_w.presc),
        .div_sel (ctrl_w.div_sel),
        .tick    (tick_w)
    );

    wdog_count #(.CNT_INIT(CNT_INIT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .load_we  (kick_w),
        .load_val (wdata),
        .reload   (reload_w),
        .cnt      (cnt_w),
        .expire   (expire_w)
    );

    wdog_rstgen #(.RST_LEN(RST_LEN)) u_rstgen (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire_w && rst_en_w),
        .pulse (wdt_rst)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int unsigned RST_LEN = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [15:0] wdata,
    input logic        wdt_rst,
    input logic        wdt_irq,
    input logic [15:0] cnt,
    input logic        tick,
    input logic        expire,
    input logic        run,
    input logic        rst_en,
    input logic        irq_en
);
    localparam int unsigned HW = $clog2(RST_LEN + 2) + 1;

    logic          kick;
    logic          ack;
    logic [HW-1:0] hi_run;

    assign kick = wr_en && (addr == 4'h8);
    assign ack  = wr_en && (addr == 4'hC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (expire && rst_en) begin
            hi_run <= HW'(1);
        end else if (wdt_rst) begin
            hi_run <= hi_run + HW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R5
    kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> cnt == $past(wdata));

    // R4
    tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !kick && cnt > 16'd1) |=> cnt == $past(cnt) - 16'd1);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> $stable(cnt));

    // R7
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rst_en) |=> wdt_rst);

    // R7
    rst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (hi_run >= HW'(1) && hi_run <= HW'(RST_LEN)));

    // R7
    rst_len_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst) |-> $past(hi_run) == HW'(RST_LEN));

    // R9
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst && !(expire && rst_en)) |=> !wdt_rst);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_en) |=> wdt_irq);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && !ack) |=> wdt_irq);

    // R8
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> !wdt_irq);
endmodule

bind wdog_timer wdog_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .wdt_rst (wdt_rst),
    .wdt_irq (wdt_irq),
    .cnt     (cnt_w),
    .tick    (tick_w),
    .expire  (expire_w),
    .run     (run_w),
    .rst_en  (rst_en_w),
    .irq_en  (irq_en_w)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        wdt_rst;
    logic        wdt_irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    wdog_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .wdt_rst (wdt_rst),
        .wdt_irq (wdt_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(4'h0, v); check("R1 ctrl reset", v, 16'h0021);
        peek(4'h4, v); check("R1 reload reset", v, 16'h8000);
        peek(4'h8, v); check("R1 count reset", v, 16'h8000);
        check("R1 irq reset", {15'h0, wdt_irq}, 16'h0);
        check("R1 rst reset", {15'h0, wdt_rst}, 16'h0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'h1234);
        peek(4'h4, v); check("R2 reload readback", v, 16'h1234);
        wr(4'h0, 16'hAB46);
        peek(4'h0, v); check("R2 ctrl readback", v, 16'hAB46);
        peek(4'hC, v); check("R2 ack reads zero", v, 16'h0000);
        wr(4'h8, 16'h0777);
        peek(4'h8, v); check("R2 count readback", v, 16'h0777);
        wr(4'h2, 16'hFFFF);
        peek(4'h0, v); check("R2 stray write ctrl", v, 16'hAB46);
        peek(4'h4, v); check("R2 stray write reload", v, 16'h1234);
        peek(4'h2, v); check("R2 stray read zero", v, 16'h0000);
        wait_cyc(200);
        peek(4'h8, v); check("R6 halted count", v, 16'h0777);
        check("R6 halted no irq", {15'h0, wdt_irq}, 16'h0);
    endtask

    task automatic t_interval();
        logic [15:0] v;
        wr(4'h0, 16'h0024);
        wr(4'h4, 16'h0003);
        wr(4'h8, 16'h0003);
        wait_cyc(15);
        peek(4'h8, v); check("R3 before first tick", v, 16'h0003);
        wait_cyc(1);
        peek(4'h8, v); check("R4 first tick", v, 16'h0002);
        wait_cyc(31);
        peek(4'h8, v); check("R4 count before expiry", v, 16'h0001);
        check("R8 irq before expiry", {15'h0, wdt_irq}, 16'h0);
        wait_cyc(1);
        check("R8 irq at expiry", {15'h0, wdt_irq}, 16'h1);
        peek(4'h8, v); check("R4 reload on expiry", v, 16'h0003);
        check("R9 no rst in timer mode", {15'h0, wdt_rst}, 16'h0);
        wait_cyc(48);
        peek(4'h8, v); check("R4 second reload", v, 16'h0003);
        check("R8 irq held", {15'h0, wdt_irq}, 16'h1);
        wr(4'hC, 16'h0000);
        check("R8 irq cleared", {15'h0, wdt_irq}, 16'h0);
    endtask

    task automatic t_div();
        logic [15:0] v;
        wr(4'h0, 16'h0238);
        wr(4'h8, 16'h0002);
        wait_cyc(383);
        peek(4'h8, v); check("R3 presc2 div128 hold", v, 16'h0002);
        wait_cyc(1);
        peek(4'h8, v); check("R3 presc2 div128 tick", v, 16'h0001);
        wr(4'h0, 16'h0028);
        wr(4'h8, 16'h0005);
        wait_cyc(31);
        peek(4'h8, v); check("R3 div32 hold", v, 16'h0005);
        wait_cyc(1);
        peek(4'h8, v); check("R3 div32 tick", v, 16'h0004);
        wr(4'h0, 16'h0030);
        wr(4'h8, 16'h0005);
        wait_cyc(63);
        peek(4'h8, v); check("R3 div64 hold", v, 16'h0005);
        wait_cyc(1);
        peek(4'h8, v); check("R3 div64 tick", v, 16'h0004);
    endtask

    task automatic t_rstpulse();
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'hFFFF);
        wr(4'h0, 16'h0021);
        wr(4'h8, 16'h0001);
        wait_cyc(15);
        check("R7 rst before expiry", {15'h0, wdt_rst}, 16'h0);
        wait_cyc(1);
        check("R7 rst rises", {15'h0, wdt_rst}, 16'h1);
        wait_cyc(127);
        check("R7 rst last cycle", {15'h0, wdt_rst}, 16'h1);
        check("R9 no irq when disabled", {15'h0, wdt_irq}, 16'h0);
        wait_cyc(1);
        check("R7 rst ends after 128", {15'h0, wdt_rst}, 16'h0);
        wr(4'h0, 16'h0024);
        wr(4'h8, 16'h0001);
        wait_cyc(16);
        check("R9 irq only expiry", {15'h0, wdt_irq}, 16'h1);
        wait_cyc(4);
        check("R9 no rst pulse", {15'h0, wdt_rst}, 16'h0);
        wr(4'hC, 16'h0000);
    endtask

    task automatic t_kick();
        wr(4'h0, 16'h0124);
        wr(4'hC, 16'h0000);
        wr(4'h8, 16'h0002);
        wait_cyc(40);
        wr(4'h8, 16'h0002);
        wait_cyc(63);
        check("R5 old timeout cancelled", {15'h0, wdt_irq}, 16'h0);
        wait_cyc(1);
        check("R5 timeout after kick", {15'h0, wdt_irq}, 16'h1);
    endtask

    task automatic t_zero();
        logic [15:0] v;
        wr(4'h0, 16'h0024);
        wr(4'hC, 16'h0000);
        wr(4'h4, 16'h0005);
        wr(4'h8, 16'h0000);
        wait_cyc(15);
        check("R4 zero before tick", {15'h0, wdt_irq}, 16'h0);
        wait_cyc(1);
        check("R4 zero expires first tick", {15'h0, wdt_irq}, 16'h1);
        peek(4'h8, v); check("R4 zero reload", v, 16'h0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_interval();
        t_div();
        t_rstpulse();
        t_kick();
        t_zero();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: bench did not finish, actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule